// File: doc/BRIEF.md
# Duplicate Tag Store with Diagnostic Parity Port

This block holds a duplicate copy of cache tags. It has 2^IDX_W entries, and each entry stores a TAG_W-bit tag with one parity bit beside it. Entries are filled in normal operation through a tag-write port, which computes even parity for each stored tag. Every memory read presents an index. The block returns that entry one cycle later and recomputes parity on it. A mismatch raises a per-lookup error pulse and sets a sticky error flag.

Test software can reach the array through a 32-bit data register and a small control register. It loads a tag and a raw parity bit into the data register, then arms a deferred write or a deferred read and enables the force-ignore qualifier. The armed access does not take an address of its own. It waits for the next memory read and acts on the index of that read. A deferred write stores the parity bit exactly as software gave it, which lets a bad-parity entry be planted on purpose. A deferred read copies the looked-up entry back into the data register.

Top module: `dtag_diag_ram`

## Requirements
- R1: After reset the data register, both arm flags, the force-ignore bit and the sticky error flag all read zero.
- R2: A data-register write keeps bits 19:0 (tag in 19:1, parity in 0). Bits 31:20 always read zero, whatever value was written to them.
- R3: A tag write stores the tag together with its even parity bit (the XOR of the tag bits). When mr_valid is high, lk_valid, lk_tag and lk_par show that entry in the following cycle.
- R4: lk_perr is high together with lk_valid whenever the XOR of the returned tag and parity is 1. The sticky flag (ctl bit 3) sets one cycle later and stays set. Writing ctl with bit 3 equal to 1 clears it, and writing bit 3 equal to 0 leaves it unchanged.
- R5: When arm-write (ctl bit 1) and force-ignore (ctl bit 2) are both set, the next memory read writes data-register bits 19:1 as the tag and bit 0 as the parity, unchanged, at that read's index. Arm-write then clears.
- R6: When arm-read (ctl bit 0) and force-ignore are both set, the next memory read copies the looked-up entry into the data register one cycle after lk_valid. Arm-read then clears, and the entry is parity-checked like any other lookup.
- R7: While force-ignore is clear, memory reads leave the arm flags and the data register untouched.
- R8: If both arm flags are set, one memory read services only the write. The read stays armed and is serviced on the following memory read.
- R9: A lookup returns the entry contents as they were before any write that happens on the same clock edge.
- R10: If a tag write and a deferred write hit the same index on the same edge, the deferred write's value is the one stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Data-register write strobe |
| reg_wdata | input | 32 | Data-register write value |
| reg_rdata | output | 32 | Data-register contents |
| ctl_wr | input | 1 | Control write strobe |
| ctl_wdata | input | 4 | {clear-error, force-ignore, arm-write, arm-read} |
| ctl_rdata | output | 4 | {error, force-ignore, arm-write, arm-read} |
| tw_en | input | 1 | Normal tag write enable |
| tw_idx | input | 8 | Tag write index |
| tw_tag | input | 19 | Tag to store |
| mr_valid | input | 1 | Memory read lookup strobe |
| mr_idx | input | 8 | Memory read tag index |
| lk_valid | output | 1 | Lookup result valid |
| lk_tag | output | 19 | Looked-up tag |
| lk_par | output | 1 | Looked-up stored parity |
| lk_perr | output | 1 | Parity mismatch on this lookup |

## Verification
The bench plants an entry with inverted parity and confirms that the next lookup flags it. A design that ran deferred writes through the parity generator would return clean parity and never raise the error. The write-one-to-clear behaviour is tested with a zero write first, which exposes a flag that clears on any control write. Both-armed and unqualified arming show whether a design services two accesses on one read, or acts without force-ignore. A same-edge collision checks that a lookup sees the old contents and that the deferred write beats the normal write.

// File: rtl/dtag_diag_ram.sv
module dtag_diag_ram #(
  parameter int IDX_W = 8,
  parameter int TAG_W = 19,
  parameter int REG_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             ctl_wr,
  input  logic [3:0]       ctl_wdata,
  output logic [3:0]       ctl_rdata,
  input  logic             tw_en,
  input  logic [IDX_W-1:0] tw_idx,
  input  logic [TAG_W-1:0] tw_tag,
  input  logic             mr_valid,
  input  logic [IDX_W-1:0] mr_idx,
  output logic             lk_valid,
  output logic [TAG_W-1:0] lk_tag,
  output logic             lk_par,
  output logic             lk_perr
);
  localparam int DEPTH = 1 << IDX_W;
  localparam int RSV_W = REG_W - TAG_W - 1;

  logic [TAG_W:0] mem [DEPTH];
  logic [TAG_W:0] dreg, lk_ent;
  logic arm_rd, arm_wr, frc, perr, cap_pend;

  wire svc    = mr_valid & frc;
  wire do_dwr = svc & arm_wr;
  wire do_drd = svc & arm_rd & ~arm_wr;

  always_ff @(posedge clk) begin
    if (tw_en)  mem[tw_idx] <= {tw_tag, ^tw_tag};
    if (do_dwr) mem[mr_idx] <= dreg;
    if (mr_valid) lk_ent <= mem[mr_idx];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lk_valid <= 1'b0;
      cap_pend <= 1'b0;
    end else begin
      lk_valid <= mr_valid;
      cap_pend <= do_drd;
    end
  end

  assign lk_tag  = lk_ent[TAG_W:1];
  assign lk_par  = lk_ent[0];
  assign lk_perr = lk_valid & (^lk_ent);

  always_ff @(posedge clk) begin
    if (!rst_n) dreg <= '0;
    else if (cap_pend) dreg <= lk_ent;
    else if (reg_wr) dreg <= reg_wdata[TAG_W:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      arm_rd <= 1'b0;
      arm_wr <= 1'b0;
      frc    <= 1'b0;
    end else if (ctl_wr) begin
      arm_rd <= ctl_wdata[0];
      arm_wr <= ctl_wdata[1];
      frc    <= ctl_wdata[2];
    end else begin
      if (do_dwr) arm_wr <= 1'b0;
      if (do_drd) arm_rd <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) perr <= 1'b0;
    else if (lk_perr) perr <= 1'b1;
    else if (ctl_wr && ctl_wdata[3]) perr <= 1'b0;
  end

  assign reg_rdata = {{RSV_W{1'b0}}, dreg};
  assign ctl_rdata = {perr, frc, arm_wr, arm_rd};
endmodule

// File: rtl/dtag_diag_ram_chk.sv
module dtag_diag_ram_chk #(
  parameter int IDX_W = 8,
  parameter int TAG_W = 19,
  parameter int REG_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_wr,
  input logic [REG_W-1:0] reg_wdata,
  input logic [REG_W-1:0] reg_rdata,
  input logic             ctl_wr,
  input logic [3:0]       ctl_wdata,
  input logic [3:0]       ctl_rdata,
  input logic             tw_en,
  input logic [IDX_W-1:0] tw_idx,
  input logic [TAG_W-1:0] tw_tag,
  input logic             mr_valid,
  input logic [IDX_W-1:0] mr_idx,
  input logic             lk_valid,
  input logic [TAG_W-1:0] lk_tag,
  input logic             lk_par,
  input logic             lk_perr
);
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n) reg_rdata[REG_W-1:TAG_W+1] == '0); // R2
  AST_LK_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n) mr_valid |=> lk_valid); // R3
  AST_LK_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !mr_valid |=> !lk_valid); // R3
  AST_PERR_QUAL: assert property (@(posedge clk) disable iff (!rst_n) lk_perr |-> lk_valid); // R4
  AST_PERR_SET: assert property (@(posedge clk) disable iff (!rst_n) lk_perr |=> ctl_rdata[3]); // R4
  AST_PERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_rdata[3] && !(ctl_wr && ctl_wdata[3]) |=> ctl_rdata[3]); // R4
  AST_ARM_WR_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_rdata[1] && ctl_rdata[2] && mr_valid && !ctl_wr |=> !ctl_rdata[1]); // R5
  AST_NO_FRC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_rdata[2] && !ctl_wr |=> $stable(ctl_rdata[1:0])); // R7
  AST_WR_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_rdata[0] && ctl_rdata[1] && ctl_rdata[2] && mr_valid && !ctl_wr |=> ctl_rdata[0]); // R8
endmodule

bind dtag_diag_ram dtag_diag_ram_chk #(.IDX_W(IDX_W), .TAG_W(TAG_W), .REG_W(REG_W)) chk_i (.*);

// File: tb/dtag_diag_ram_tb.sv
module dtag_diag_ram_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0, ctl_wr = 1'b0, tw_en = 1'b0, mr_valid = 1'b0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic [3:0]  ctl_wdata = '0, ctl_rdata;
  logic [7:0]  tw_idx = '0, mr_idx = '0;
  logic [18:0] tw_tag = '0, lk_tag;
  logic lk_valid, lk_par, lk_perr;
  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [20:0] exp_q [$];

  always #2 clk = ~clk;

  dtag_diag_ram dut_i (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) if (lk_valid) begin
    logic [20:0] e;
    if (exp_q.size() == 0) begin
      checks++; fails++;
      $display("FAIL R3 actual=unexpected lookup expected=none");
    end else begin
      e = exp_q.pop_front();
      check("R3 lk_tag", 32'(lk_tag), 32'(e[20:2]));
      check("R3 lk_par", 32'(lk_par), 32'(e[1]));
      check("R4 lk_perr", 32'(lk_perr), 32'(e[0]));
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic reg_write(logic [31:0] v);
    @(negedge clk); reg_wr = 1; reg_wdata = v; @(negedge clk); reg_wr = 0;
  endtask
  task automatic ctl_write(logic [3:0] v);
    @(negedge clk); ctl_wr = 1; ctl_wdata = v; @(negedge clk); ctl_wr = 0;
  endtask
  task automatic tag_write(logic [7:0] i, logic [18:0] t);
    @(negedge clk); tw_en = 1; tw_idx = i; tw_tag = t; @(negedge clk); tw_en = 0;
  endtask
  task automatic mem_read(logic [7:0] i, logic [18:0] t, logic p);
    @(negedge clk); mr_valid = 1; mr_idx = i;
    exp_q.push_back({t, p, ^{t, p}});
    @(negedge clk); mr_valid = 0;
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk); cyc++;
      if (cyc > 20000) begin
        checks++; fails++;
        $display("FAIL watchdog actual=%0d expected<20000", cyc);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    idle(3); rst_n = 1; idle(1);
    check("R1 reg", reg_rdata, 0);
    check("R1 ctl", 32'(ctl_rdata), 0);

    reg_write(32'hFFFF_FFFF);
    idle(1); check("R2 reserved", reg_rdata, 32'h000F_FFFF);

    tag_write(8'd5, 19'h12345); tag_write(8'd6, 19'h00001);
    tag_write(8'd7, 19'h00000); tag_write(8'd9, 19'h00003);
    tag_write(8'd10, 19'h00002);
    mem_read(8'd5, 19'h12345, ^19'h12345);
    mem_read(8'd6, 19'h00001, 1'b1);
    mem_read(8'd7, 19'h00000, 1'b0);

    reg_write({12'hABC, 19'h70F0F, ~^19'h70F0F});
    ctl_write(4'b0110);
    mem_read(8'd9, 19'h00003, 1'b0);                 // R9 old contents
    idle(1); check("R5 arm clears", 32'(ctl_rdata), 32'h4);
    mem_read(8'd9, 19'h70F0F, ~^19'h70F0F);          // R5 raw parity planted
    idle(2); check("R4 sticky set", 32'(ctl_rdata), 32'hC);
    ctl_write(4'b0100); idle(1);
    check("R4 zero write keeps", 32'(ctl_rdata), 32'hC);
    ctl_write(4'b1100); idle(1);
    check("R4 clear", 32'(ctl_rdata), 32'h4);

    ctl_write(4'b0101);
    mem_read(8'd5, 19'h12345, ^19'h12345);
    idle(2);
    check("R6 capture", reg_rdata, {12'h0, 19'h12345, ^19'h12345});
    check("R6 arm clears", 32'(ctl_rdata), 32'h4);

    ctl_write(4'b0001);
    mem_read(8'd6, 19'h00001, 1'b1);
    idle(2);
    check("R7 reg untouched", reg_rdata, {12'h0, 19'h12345, ^19'h12345});
    check("R7 still armed", 32'(ctl_rdata), 32'h1);
    ctl_write(4'b0101);
    mem_read(8'd6, 19'h00001, 1'b1);
    idle(2); check("R6 capture idx6", reg_rdata, {12'h0, 19'h00001, 1'b1});

    reg_write({12'hFFF, 19'h55555, ^19'h55555});
    ctl_write(4'b0111);
    mem_read(8'd7, 19'h00000, 1'b0);
    idle(1); check("R8 read pending", 32'(ctl_rdata), 32'h5);
    mem_read(8'd7, 19'h55555, ^19'h55555);
    idle(2);
    check("R8 read serviced", reg_rdata, {12'h0, 19'h55555, ^19'h55555});
    check("R8 flags clear", 32'(ctl_rdata), 32'h4);

    reg_write({12'h0, 19'h0AAAA, ^19'h0AAAA});
    ctl_write(4'b0110);
    @(negedge clk);
    tw_en = 1; tw_idx = 8'd10; tw_tag = 19'h11111;
    mr_valid = 1; mr_idx = 8'd10; exp_q.push_back({19'h00002, 1'b1, 1'b0}); // R9
    @(negedge clk); tw_en = 0; mr_valid = 0;
    mem_read(8'd10, 19'h0AAAA, ^19'h0AAAA);          // R10 deferred wins
    idle(3);
    check("R3 queue drained", exp_q.size(), 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule